// File: doc/BRIEF.md
# RFID Open-State Authentication Command Handler

This block sits in a passive tag's protocol logic after the physical-layer decoder and CRC checker. It receives reader commands that have already been decoded and follows the tag's protocol states. Once the tag has been singulated and issued a session handle, the block runs a three-command authentication exchange inside the open state.

The exchange works as follows. A data-send command delivers a 64-bit nonce, and the block starts the response engine with it. When the engine reports completion, the block acknowledges with the handle. A later fetch command returns the handle, the tag's random value R and the concatenated response words w_1 .. w_q.

Replies are streamed 16 bits per beat on a valid/data/last output. A later stage appends the CRC-16 and modulates the reply. The tag never transmits unless a reader command or the completion of that command's computation calls for it.

Top module: `tag_auth_cmd_handler`

## Requirements
- R1: After reset the tag state is ready (code 0), reply_valid is low and eng_start is low.
- R2: State codes are ready=0, arbitrate=1, reply=2, acknowledged=3, open=4, killed=5, and opcodes are query=1, ack=2, handle-request=3, data-send=4, fetch=5, nak=6, kill=7. Query moves ready or arbitrate to reply. Ack moves reply to acknowledged. Nak moves reply, acknowledged or open to arbitrate. Any other command leaves the state unchanged.
- R3: A handle-request in acknowledged latches rng_handle as the session handle, enters open and replies with one beat carrying that handle, with reply_last high.
- R4: A data-send in open with a matching handle pulses eng_start for exactly one cycle, in the cycle after the command, with eng_nonce equal to cmd_payload.
- R5: An eng_done pulse while a computation is outstanding produces, in the next cycle, a one-beat acknowledge carrying the session handle with reply_last high. An eng_done pulse with no computation outstanding produces nothing.
- R6: A fetch in open with a matching handle, after a completed computation, yields 20 consecutive beats in this order: the handle; R in 4 beats, most significant first; the 240 response bits in 15 beats, with w_1 in the top nibble of the first of those beats. reply_last is high on the 20th beat only.
- R7: A fetch before any nonce has been received, or while a computation is outstanding, produces no reply.
- R8: A data-send during a computation restarts the engine with the new nonce. An eng_done that arrives in the same cycle as that command, or in the cycle eng_start is high, is ignored. Only a later completion is acknowledged, and the fetched R comes from it.
- R9: Data-send, fetch and kill whose handle differs from the session handle are ignored: no start, no reply, no state change.
- R10: A command whose cmd_crc_ok is low is discarded without any change of state and without a reply.
- R11: Data-send and fetch outside the open state are ignored.
- R12: Kill with a matching handle in open moves to killed, and killed ignores every later command. Leaving open through nak or kill discards the session result.
- R13: Commands that arrive while a reply is being streamed are dropped.
- R14: reply_valid rises only in the cycle after an incoming command or an engine completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_handle | input | HANDLE_W | Session handle carried by the command |
| cmd_payload | input | NONCE_W | Command payload (nonce for data-send) |
| cmd_crc_ok | input | 1 | The command passed its CRC check |
| rng_handle | input | HANDLE_W | Fresh random handle from the tag's random source |
| eng_start | output | 1 | One-cycle start pulse to the response engine |
| eng_nonce | output | NONCE_W | Nonce handed to the engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_rand | input | RAND_W | Random value R from the engine |
| eng_resp | input | W_BITS*W_COUNT | Concatenated response words, w_1 most significant |
| reply_valid | output | 1 | Reply beat valid |
| reply_data | output | BEAT_W | Reply beat |
| reply_last | output | 1 | Final beat of the reply |
| tag_state | output | 3 | Current protocol state code |

## Verification
Engine completion and the arrival of a new nonce can fall in the same cycle. A stale completion can also land in the very cycle the restart pulse leaves the block. The bench keeps the engine's completion line under manual control and raises it together with a data-send, then holds it through the following start cycle. A correct design sends no acknowledge in either case. When a completion is finally raised on its own, the design sends exactly one acknowledge, and a fetch then returns the R that belongs to the newer nonce.

// File: rtl/tag_auth_pkg.sv
package tag_auth_pkg;

    typedef enum logic [2:0] {
        ST_READY  = 3'd0,
        ST_ARB    = 3'd1,
        ST_REPLY  = 3'd2,
        ST_ACKED  = 3'd3,
        ST_OPEN   = 3'd4,
        ST_KILLED = 3'd5
    } tag_state_e;

    typedef enum logic [3:0] {
        OP_QUERY      = 4'd1,
        OP_ACK        = 4'd2,
        OP_REQ_HANDLE = 4'd3,
        OP_SEND_DATA  = 4'd4,
        OP_GET_DATA   = 4'd5,
        OP_NAK        = 4'd6,
        OP_KILL       = 4'd7
    } cmd_op_e;

endpackage

// File: rtl/tag_auth_state.sv
module tag_auth_state
    import tag_auth_pkg::*;
#(
    parameter int HANDLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_ok,
    input  logic [3:0]          cmd_op,
    input  logic [HANDLE_W-1:0] cmd_handle,
    input  logic [HANDLE_W-1:0] rng_handle,
    output tag_state_e          state_o,
    output logic [HANDLE_W-1:0] handle_o,
    output logic                send_go,
    output logic                get_go,
    output logic                issue_handle,
    output logic                leave_open
);

    typedef struct packed {
        tag_state_e          state;
        logic [HANDLE_W-1:0] handle;
    } fsm_s;

    fsm_s st_d, st_q;
    logic h_match;

    assign h_match = (cmd_handle == st_q.handle);

    always_comb begin
        st_d         = st_q;
        send_go      = 1'b0;
        get_go       = 1'b0;
        issue_handle = 1'b0;
        leave_open   = 1'b0;
        if (cmd_ok) begin
            unique case (st_q.state)
                ST_READY, ST_ARB: begin
                    if (cmd_op == OP_QUERY) st_d.state = ST_REPLY;
                end
                ST_REPLY: begin
                    if (cmd_op == OP_ACK)      st_d.state = ST_ACKED;
                    else if (cmd_op == OP_NAK) st_d.state = ST_ARB;
                end
                ST_ACKED: begin
                    if (cmd_op == OP_REQ_HANDLE) begin
                        st_d.state   = ST_OPEN;
                        st_d.handle  = rng_handle;
                        issue_handle = 1'b1;
                    end else if (cmd_op == OP_NAK) begin
                        st_d.state = ST_ARB;
                    end
                end
                ST_OPEN: begin
                    if (cmd_op == OP_NAK) begin
                        st_d.state = ST_ARB;
                        leave_open = 1'b1;
                    end else if (h_match) begin
                        if (cmd_op == OP_SEND_DATA) send_go = 1'b1;
                        if (cmd_op == OP_GET_DATA)  get_go  = 1'b1;
                        if (cmd_op == OP_KILL) begin
                            st_d.state = ST_KILLED;
                            leave_open = 1'b1;
                        end
                    end
                end
                ST_KILLED: ;
                default: st_d.state = ST_READY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state  <= ST_READY;
            st_q.handle <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o  = st_q.state;
    assign handle_o = st_q.handle;

    // R12: killed is absorbing
    a_r12_killed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.state == ST_KILLED |=> st_q.state == ST_KILLED);

    // R3: open is only entered through a handle request
    a_r3_open_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_OPEN && $past(st_q.state) != ST_OPEN)
        |-> $past(cmd_ok && cmd_op == OP_REQ_HANDLE));

endmodule

// File: rtl/tag_auth_session.sv
module tag_auth_session #(
    parameter int NONCE_W = 64,
    parameter int RAND_W  = 64,
    parameter int RESP_W  = 240
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               send_go,
    input  logic [NONCE_W-1:0] nonce_in,
    input  logic               clear,
    input  logic               eng_done,
    input  logic [RAND_W-1:0]  eng_rand,
    input  logic [RESP_W-1:0]  eng_resp,
    output logic               eng_start,
    output logic [NONCE_W-1:0] eng_nonce,
    output logic               ack_fire,
    output logic               result_valid,
    output logic [RAND_W-1:0]  rnd_o,
    output logic [RESP_W-1:0]  resp_o
);

    typedef struct packed {
        logic               busy;
        logic               have;
        logic               start;
        logic [NONCE_W-1:0] nonce;
        logic [RAND_W-1:0]  rnd;
        logic [RESP_W-1:0]  resp;
    } sess_s;

    sess_s ss_d, ss_q;

    always_comb begin
        ss_d       = ss_q;
        ss_d.start = 1'b0;
        ack_fire   = 1'b0;
        if (send_go) begin
            ss_d.busy  = 1'b1;
            ss_d.have  = 1'b0;
            ss_d.start = 1'b1;
            ss_d.nonce = nonce_in;
        end else if (clear) begin
            ss_d.busy = 1'b0;
            ss_d.have = 1'b0;
        end else if (ss_q.busy && !ss_q.start && eng_done) begin
            ss_d.busy = 1'b0;
            ss_d.have = 1'b1;
            ss_d.rnd  = eng_rand;
            ss_d.resp = eng_resp;
            ack_fire  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ss_q <= '0;
        end else begin
            ss_q <= ss_d;
        end
    end

    assign eng_start    = ss_q.start;
    assign eng_nonce    = ss_q.nonce;
    assign result_valid = ss_q.have;
    assign rnd_o        = ss_q.rnd;
    assign resp_o       = ss_q.resp;

    // R4: a start pulse is always caused by an accepted data-send
    a_r4_start_after_send: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $past(send_go));

    // R8: restarting discards the previous result
    a_r8_start_clears_result: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !result_valid);

    // R5: a result only appears after an engine completion
    a_r5_result_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_valid) |-> $past(eng_done));

endmodule

// File: rtl/tag_auth_reply.sv
module tag_auth_reply #(
    parameter int HANDLE_W = 16,
    parameter int RAND_W   = 64,
    parameter int RESP_W   = 240,
    parameter int BEAT_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_short,
    input  logic                load_full,
    input  logic [HANDLE_W-1:0] handle,
    input  logic [RAND_W-1:0]   rnd,
    input  logic [RESP_W-1:0]   resp,
    output logic                reply_valid,
    output logic [BEAT_W-1:0]   reply_data,
    output logic                reply_last,
    output logic                busy
);

    localparam int FRAME_W = HANDLE_W + RAND_W + RESP_W;
    localparam int BEATS   = FRAME_W / BEAT_W;
    localparam int CNT_W   = $clog2(BEATS + 1);
    localparam int PAD_W   = FRAME_W - HANDLE_W;

    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   left;
    } ser_s;

    ser_s sr_d, sr_q;
    logic [FRAME_W-1:0] short_frame;

    generate
        if (PAD_W > 0) begin : g_pad
            assign short_frame = {handle, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign short_frame = handle;
        end
    endgenerate

    always_comb begin
        sr_d = sr_q;
        if (sr_q.left != '0) begin
            sr_d.shreg = sr_q.shreg << BEAT_W;
            sr_d.left  = sr_q.left - CNT_W'(1);
        end
        if (load_full) begin
            sr_d.shreg = {handle, rnd, resp};
            sr_d.left  = CNT_W'(BEATS);
        end else if (load_short) begin
            sr_d.shreg = short_frame;
            sr_d.left  = CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign reply_valid = (sr_q.left != '0);
    assign reply_last  = (sr_q.left == CNT_W'(1));
    assign reply_data  = sr_q.shreg[FRAME_W-1 -: BEAT_W];
    assign busy        = reply_valid;

    // R6: the last beat closes the stream
    a_r6_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        reply_valid && reply_last |=> !reply_valid);

    // R13: no new frame is loaded over a running stream
    a_r13_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(load_full || load_short));

endmodule

// File: rtl/tag_auth_cmd_handler.sv
module tag_auth_cmd_handler
    import tag_auth_pkg::*;
#(
    parameter int HANDLE_W = 16,
    parameter int NONCE_W  = 64,
    parameter int RAND_W   = 64,
    parameter int W_BITS   = 4,
    parameter int W_COUNT  = 60,
    parameter int BEAT_W   = 16,
    localparam int RESP_W  = W_BITS * W_COUNT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [3:0]          cmd_op,
    input  logic [HANDLE_W-1:0] cmd_handle,
    input  logic [NONCE_W-1:0]  cmd_payload,
    input  logic                cmd_crc_ok,
    input  logic [HANDLE_W-1:0] rng_handle,
    output logic                eng_start,
    output logic [NONCE_W-1:0]  eng_nonce,
    input  logic                eng_done,
    input  logic [RAND_W-1:0]   eng_rand,
    input  logic [RESP_W-1:0]   eng_resp,
    output logic                reply_valid,
    output logic [BEAT_W-1:0]   reply_data,
    output logic                reply_last,
    output logic [2:0]          tag_state
);

    logic                cmd_ok;
    logic                ser_busy;
    tag_state_e          st;
    logic [HANDLE_W-1:0] handle_q;
    logic                send_go, get_go, issue_handle, leave_open;
    logic                ack_fire, result_valid;
    logic [RAND_W-1:0]   rnd_q;
    logic [RESP_W-1:0]   resp_q;
    logic                load_short, load_full;
    logic [HANDLE_W-1:0] reply_handle;

    assign cmd_ok = cmd_valid && cmd_crc_ok && !ser_busy;

    tag_auth_state #(.HANDLE_W(HANDLE_W)) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_ok       (cmd_ok),
        .cmd_op       (cmd_op),
        .cmd_handle   (cmd_handle),
        .rng_handle   (rng_handle),
        .state_o      (st),
        .handle_o     (handle_q),
        .send_go      (send_go),
        .get_go       (get_go),
        .issue_handle (issue_handle),
        .leave_open   (leave_open)
    );

    tag_auth_session #(
        .NONCE_W (NONCE_W),
        .RAND_W  (RAND_W),
        .RESP_W  (RESP_W)
    ) u_session (
        .clk          (clk),
        .rst_n        (rst_n),
        .send_go      (send_go),
        .nonce_in     (cmd_payload),
        .clear        (leave_open),
        .eng_done     (eng_done),
        .eng_rand     (eng_rand),
        .eng_resp     (eng_resp),
        .eng_start    (eng_start),
        .eng_nonce    (eng_nonce),
        .ack_fire     (ack_fire),
        .result_valid (result_valid),
        .rnd_o        (rnd_q),
        .resp_o       (resp_q)
    );

    assign load_full    = get_go && result_valid;
    assign load_short   = issue_handle || ack_fire;
    assign reply_handle = issue_handle ? rng_handle : handle_q;

    tag_auth_reply #(
        .HANDLE_W (HANDLE_W),
        .RAND_W   (RAND_W),
        .RESP_W   (RESP_W),
        .BEAT_W   (BEAT_W)
    ) u_reply (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_short  (load_short),
        .load_full   (load_full),
        .handle      (reply_handle),
        .rnd         (rnd_q),
        .resp        (resp_q),
        .reply_valid (reply_valid),
        .reply_data  (reply_data),
        .reply_last  (reply_last),
        .busy        (ser_busy)
    );

    assign tag_state = st;

    // R14: the tag only speaks when prompted
    a_r14_no_unprompted: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reply_valid) |-> $past(cmd_valid || eng_done));

    // R10: a command with a bad CRC changes no state
    a_r10_crc_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_crc_ok) |=> ($stable(tag_state) && !eng_start));

    // R13: commands during a stream change no state
    a_r13_stream_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (reply_valid && cmd_valid) |=> $stable(tag_state));

    // R9: a data-send with a foreign handle starts nothing
    a_r9_mismatch_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_SEND_DATA && cmd_handle != handle_q)
        |=> !eng_start);

    // R11: a data-send outside open starts nothing
    a_r11_closed_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_SEND_DATA && tag_state != 3'd4)
        |=> !eng_start);

endmodule

// File: tb/tag_auth_cmd_handler_tb.sv
module tag_auth_cmd_handler_tb;

    localparam int RESP_W = 240;
    localparam logic [15:0] H  = 16'hA5C3;
    localparam logic [15:0] H2 = 16'h3C5A;
    localparam int NV = 12;

    // fields: [13:10] opcode, [9] good handle, [8] crc ok, [7:5] expected state, [4:0] expected beats
    localparam logic [13:0] VEC [NV] = '{
        {4'd1, 1'b1, 1'b0, 3'd0, 5'd0},
        {4'd5, 1'b1, 1'b1, 3'd0, 5'd0},
        {4'd1, 1'b1, 1'b1, 3'd2, 5'd0},
        {4'd3, 1'b1, 1'b1, 3'd2, 5'd0},
        {4'd2, 1'b1, 1'b1, 3'd3, 5'd0},
        {4'd6, 1'b1, 1'b1, 3'd1, 5'd0},
        {4'd1, 1'b1, 1'b1, 3'd2, 5'd0},
        {4'd2, 1'b1, 1'b1, 3'd3, 5'd0},
        {4'd4, 1'b1, 1'b1, 3'd3, 5'd0},
        {4'd3, 1'b1, 1'b1, 3'd4, 5'd1},
        {4'd7, 1'b0, 1'b1, 3'd4, 5'd0},
        {4'd5, 1'b1, 1'b1, 3'd4, 5'd0}
    };
    string vec_tag [NV] = '{"R10", "R11", "R2", "R2", "R2", "R2",
                            "R2", "R2", "R11", "R3", "R9", "R7"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [15:0] cmd_handle = '0;
    logic [63:0] cmd_payload = '0;
    logic        cmd_crc_ok = 1'b0;
    logic [15:0] rng_handle = H;
    logic        eng_start;
    logic [63:0] eng_nonce;
    logic        eng_done;
    logic [63:0] eng_rand;
    logic [RESP_W-1:0] eng_resp;
    logic        reply_valid;
    logic [15:0] reply_data;
    logic        reply_last;
    logic [2:0]  tag_state;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    function automatic logic [63:0] f_rand(input logic [63:0] n);
        return n ^ 64'h0F1E_2D3C_4B5A_6978;
    endfunction

    function automatic logic [RESP_W-1:0] f_resp(input logic [63:0] n);
        return {n, ~n, n[31:0], n[63:32], n[47:0] ^ 48'h1234_5678_9ABC};
    endfunction

    // response engine model
    logic        eng_auto = 1'b1;
    int          eng_lat = 6;
    logic        auto_done = 1'b0;
    logic        man_done = 1'b0;
    logic [63:0] last_nonce = '0;
    int          starts = 0;
    int          cnt = 0;

    assign eng_done = auto_done | man_done;
    assign eng_rand = f_rand(last_nonce);
    assign eng_resp = f_resp(last_nonce);

    always @(negedge clk) begin
        auto_done <= 1'b0;
        if (rst_n) begin
            if (eng_start) begin
                starts = starts + 1;
                last_nonce = eng_nonce;
                cnt = eng_lat;
            end else if (cnt != 0) begin
                cnt = cnt - 1;
                if (cnt == 0 && eng_auto) auto_done <= 1'b1;
            end
        end
    end

    tag_auth_cmd_handler u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_handle  (cmd_handle),
        .cmd_payload (cmd_payload),
        .cmd_crc_ok  (cmd_crc_ok),
        .rng_handle  (rng_handle),
        .eng_start   (eng_start),
        .eng_nonce   (eng_nonce),
        .eng_done    (eng_done),
        .eng_rand    (eng_rand),
        .eng_resp    (eng_resp),
        .reply_valid (reply_valid),
        .reply_data  (reply_data),
        .reply_last  (reply_last),
        .tag_state   (tag_state)
    );

    logic [15:0] beats [32];
    logic        lasts [32];
    int          nbeats;

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [3:0] op, input logic [15:0] h,
                          input logic [63:0] pl, input logic crc);
        @(negedge clk);
        cmd_valid   = 1'b1;
        cmd_op      = op;
        cmd_handle  = h;
        cmd_payload = pl;
        cmd_crc_ok  = crc;
        @(negedge clk);
        cmd_valid   = 1'b0;
    endtask

    task automatic collect(input int max_wait);
        int waited = 0;
        nbeats = 0;
        while (!reply_valid && waited < max_wait) begin
            @(negedge clk);
            waited++;
        end
        while (reply_valid && nbeats < 32) begin
            beats[nbeats] = reply_data;
            lasts[nbeats] = reply_last;
            nbeats++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [319:0] frame;
        int s0;
        int nlast;
        logic [63:0] r_got;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(tag_state == 3'd0, "R1 state", 64'(tag_state), 0);
        check(!reply_valid, "R1 reply_valid", 64'(reply_valid), 0);
        check(!eng_start, "R1 eng_start", 64'(eng_start), 0);

        // state walk from the vector table
        for (int i = 0; i < NV; i++) begin
            logic [13:0] v;
            v = VEC[i];
            do_cmd(v[13:10], v[9] ? H : ~H, 64'h0, v[8]);
            collect(2);
            check(tag_state == v[7:5], vec_tag[i], 64'(tag_state), 64'(v[7:5]));
            check(nbeats == int'(v[4:0]), vec_tag[i], 64'(nbeats), 64'(v[4:0]));
            if (v[4:0] == 5'd1)
                check(beats[0] == H && lasts[0], vec_tag[i], 64'(beats[0]), 64'(H));
        end

        // R4 / R5: nonce starts the engine, completion is acknowledged
        s0 = starts;
        do_cmd(4'd4, H, 64'h1111_2222_3333_4444, 1'b1);
        collect(20);
        check(starts == s0 + 1, "R4 one start pulse", 64'(starts - s0), 1);
        check(last_nonce == 64'h1111_2222_3333_4444, "R4 nonce", last_nonce, 64'h1111_2222_3333_4444);
        check(nbeats == 1, "R5 ack beats", 64'(nbeats), 1);
        check(beats[0] == H && lasts[0], "R5 ack handle", 64'(beats[0]), 64'(H));

        // R6: fetch returns the full frame
        frame = {H, f_rand(64'h1111_2222_3333_4444), f_resp(64'h1111_2222_3333_4444)};
        do_cmd(4'd5, H, 64'h0, 1'b1);
        collect(2);
        check(nbeats == 20, "R6 beat count", 64'(nbeats), 20);
        nlast = 0;
        for (int i = 0; i < 20; i++) begin
            check(beats[i] == frame[319 - 16*i -: 16], "R6 beat data",
                  64'(beats[i]), 64'(frame[319 - 16*i -: 16]));
            if (lasts[i]) nlast++;
        end
        check(lasts[19] && nlast == 1, "R6 last flag", 64'(nlast), 1);

        // R13: command during a stream is dropped
        do_cmd(4'd5, H, 64'h0, 1'b1);
        do_cmd(4'd6, H, 64'h0, 1'b1);
        repeat (25) @(negedge clk);
        check(tag_state == 3'd4, "R13 nak dropped", 64'(tag_state), 4);

        // R10: bad CRC fetch gives nothing
        do_cmd(4'd5, H, 64'h0, 1'b0);
        collect(3);
        check(nbeats == 0, "R10 crc fetch", 64'(nbeats), 0);

        // R7: fetch during computation gives nothing
        eng_lat = 20;
        do_cmd(4'd4, H, 64'hAAAA_0000_BBBB_0001, 1'b1);
        do_cmd(4'd5, H, 64'h0, 1'b1);
        collect(2);
        check(nbeats == 0, "R7 fetch while busy", 64'(nbeats), 0);
        collect(40);
        check(nbeats == 1, "R5 ack after long run", 64'(nbeats), 1);

        // R8: restart with a new nonce
        s0 = starts;
        do_cmd(4'd4, H, 64'h0000_0000_0000_0333, 1'b1);
        repeat (5) @(negedge clk);
        do_cmd(4'd4, H, 64'h4444_0000_0000_0004, 1'b1);
        collect(40);
        check(nbeats == 1, "R8 ack after restart", 64'(nbeats), 1);
        check(starts == s0 + 2, "R8 two starts", 64'(starts - s0), 2);
        collect(30);
        check(nbeats == 0, "R8 single ack", 64'(nbeats), 0);
        do_cmd(4'd5, H, 64'h0, 1'b1);
        collect(2);
        r_got = {beats[1], beats[2], beats[3], beats[4]};
        check(r_got == f_rand(64'h4444_0000_0000_0004), "R8 R of new nonce",
              r_got, f_rand(64'h4444_0000_0000_0004));

        // R9: foreign handle starts nothing
        s0 = starts;
        do_cmd(4'd4, ~H, 64'h5555, 1'b1);
        collect(3);
        check(starts == s0, "R9 no start", 64'(starts - s0), 0);
        check(nbeats == 0, "R9 no reply", 64'(nbeats), 0);

        // R8: completion colliding with a new nonce and with the start cycle
        eng_auto = 1'b0;
        do_cmd(4'd4, H, 64'h0000_0000_0000_0055, 1'b1);
        repeat (3) @(negedge clk);
        @(negedge clk);
        cmd_valid   = 1'b1;
        cmd_op      = 4'd4;
        cmd_handle  = H;
        cmd_payload = 64'h6666_7777_8888_9999;
        cmd_crc_ok  = 1'b1;
        man_done    = 1'b1;
        @(negedge clk);
        cmd_valid   = 1'b0;
        @(negedge clk);
        man_done    = 1'b0;
        collect(3);
        check(nbeats == 0, "R8 stale done ignored", 64'(nbeats), 0);
        @(negedge clk);
        man_done = 1'b1;
        @(negedge clk);
        man_done = 1'b0;
        collect(3);
        check(nbeats == 1, "R8 later done acked", 64'(nbeats), 1);
        do_cmd(4'd5, H, 64'h0, 1'b1);
        collect(2);
        r_got = {beats[1], beats[2], beats[3], beats[4]};
        check(r_got == f_rand(64'h6666_7777_8888_9999), "R8 R after collision",
              r_got, f_rand(64'h6666_7777_8888_9999));

        // R5: completion with nothing outstanding
        @(negedge clk);
        man_done = 1'b1;
        @(negedge clk);
        man_done = 1'b0;
        collect(3);
        check(nbeats == 0, "R5 idle done ignored", 64'(nbeats), 0);

        // R12: leave open, re-enter with new handle, kill
        rng_handle = H2;
        do_cmd(4'd6, H, 64'h0, 1'b1);
        check(tag_state == 3'd1, "R12 nak leaves open", 64'(tag_state), 1);
        do_cmd(4'd1, H2, 64'h0, 1'b1);
        do_cmd(4'd2, H2, 64'h0, 1'b1);
        do_cmd(4'd3, H2, 64'h0, 1'b1);
        collect(2);
        check(nbeats == 1 && beats[0] == H2, "R3 new handle", 64'(beats[0]), 64'(H2));
        do_cmd(4'd5, H2, 64'h0, 1'b1);
        collect(2);
        check(nbeats == 0, "R12 result dropped", 64'(nbeats), 0);
        do_cmd(4'd7, H2, 64'h0, 1'b1);
        check(tag_state == 3'd5, "R12 killed", 64'(tag_state), 5);
        do_cmd(4'd1, H2, 64'h0, 1'b1);
        check(tag_state == 3'd5, "R12 killed sticky", 64'(tag_state), 5);
        collect(10);
        check(nbeats == 0, "R14 silent when not asked", 64'(nbeats), 0);

        finish_run();
    end

endmodule